// File: doc/BRIEF.md
# Write-Detection Test Target

This block is a small register target used to measure and check how a host issues single writes. It sits behind two address windows. Window 0 is memory-mapped and 4096 bytes wide. Window 1 is port-mapped and 256 bytes wide; only address bits [7:0] are decoded in it.

The host picks a test by writing a test number into byte 0 of either window. The block then shows a read-only descriptor for the selected test, which the host reads to learn where and what to write:

| Bytes | Content |
|-------|---------|
| 0 | global test index |
| 1 | access width |
| 2–3 | zero padding |
| 4–7 | target offset, little-endian |
| 8 | expected data byte |
| 9–11 | zero padding |
| 12–15 | 32-bit counter of qualifying writes, little-endian |
| 16 on | zero-terminated ASCII name |

The host then writes to the target offset. The block counts each write that meets the rules of the active test.

Requests and responses travel on valid/ready channels. A request carries:
- the window select,
- an address,
- a write flag,
- a size of 1, 2 or 4 bytes,
- 32 bits of write data.

Byte lane k of the data belongs to address+k. Every accepted request produces exactly one response, and that response is valid in the cycle after acceptance. A response is held, with its data unchanged, until `rsp_ready` is high. While a response is pending and not being taken, `req_ready` is low; this is the only source of back-pressure. Write responses carry zero data.

Top module: `wdet_target`

## Requirements
- R1: After reset no test is active. Every read returns zero, and `rsp_valid` is low.
- R2: A write that covers byte 0 of window w with byte value v cancels the active test. If v < 3, the block then activates global index w*3+v, and byte 0 reads back that index. If v >= 3, no test is left active.
- R3: Activating a test sets its write counter (bytes 12–15) to zero.
- R4: Header fields of the active test:
  - byte 1 reads 1;
  - bytes 2, 3, 9, 10 and 11 read 0;
  - bytes 4–7 hold the target offset, little-endian. The offset is the test index plus 2048 for indices 0–2, or plus 128 for indices 3–5;
  - byte 8 reads 0xCE for the wildcard kind (kind 1) and 0xFA for kinds 0 and 2.
- R5: From byte 16 the header holds a name. The name is "mmio-" for indices 0–2 or "portio-" for indices 3–5, followed by "no-eventfd", "wildcard-eventfd" or "datamatch-eventfd" for kind 0, 1 or 2, and ends with a zero byte. A byte at address a reads 0 when a+1 is at or beyond 16 + name length + 1.
- R6: On a wildcard test, a write of any size whose lanes cover the target offset increments the counter by exactly one (modulo 2^32). This applies only to writes on the window the test belongs to.
- R7: On a data-matching test, a covering write counts only if its size is 1 and the byte written at the offset is 0xFA.
- R8: Writes that leave the counter unchanged:
  - writes that miss the target offset;
  - writes on the other window;
  - writes made while no test is active.
- R9: In a read response, lane k holds the header byte at address+k for k < size. Lanes at k >= size read 0.
- R10: `req_ready` = !`rsp_valid` || `rsp_ready`. Each accepted request gives one response in the next cycle. That response stays valid and stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | request can be accepted |
| req_win | input | 1 | 0 memory window, 1 port window |
| req_addr | input | 12 | byte address inside the window |
| req_we | input | 1 | 1 write, 0 read |
| req_size | input | 3 | access size in bytes (1, 2, 4) |
| req_wdata | input | 32 | write data, lane k for address+k |
| rsp_valid | output | 1 | response present |
| rsp_ready | input | 1 | response taken |
| rsp_rdata | output | 32 | read data, lane k for address+k |

## Verification
The hardest cases to reach are the near misses of the counting rule:
- a write that covers the target offset but has the wrong size;
- a write with the right size but the wrong byte value;
- a write at the right offset but on the other window.

Each of these must leave the counter untouched, and the only place to see that is bytes 12–15 of the header. The stimulus therefore activates a test and issues one such write. It then reads the counter back through the same port, alternating qualifying and non-qualifying writes so that each counted step is attributed to exactly one write. Back-pressure is reached by holding `rsp_ready` low across a pending read response.

// File: rtl/wdet_pkg.sv
package wdet_pkg;
  localparam int KINDS     = 3;
  localparam int WINDOWS   = 2;
  localparam int TESTS     = KINDS * WINDOWS;
  localparam int IDX_W     = $clog2(TESTS);
  localparam int HDR_BYTES = 16;
  localparam int MEM_AREA  = 2048;
  localparam int PORT_AREA = 128;
  localparam int WILD_KIND = 1;
  localparam logic [7:0] DATA_MATCH = 8'hFA;
  localparam logic [7:0] DATA_ANY   = 8'hCE;

  localparam logic [191:0] PFX_MEM  = "mmio-";
  localparam logic [191:0] PFX_PORT = "portio-";
  localparam logic [191:0] SFX_K0   = "no-eventfd";
  localparam logic [191:0] SFX_K1   = "wildcard-eventfd";
  localparam logic [191:0] SFX_K2   = "datamatch-eventfd";

  function automatic logic [7:0] lit_byte(logic [191:0] s, int n, int k);
    logic [191:0] sh;
    sh = s >> (8 * (n - 1 - k));
    return sh[7:0];
  endfunction

  function automatic int sfx_len(int kind);
    return (kind == 0) ? 10 : (kind == 1) ? 16 : 17;
  endfunction

  function automatic int pfx_len(int idx);
    return (idx >= KINDS) ? 7 : 5;
  endfunction

  function automatic int hdr_len(int idx);
    return HDR_BYTES + pfx_len(idx) + sfx_len(idx % KINDS) + 1;
  endfunction

  function automatic int test_offset(int idx);
    return ((idx >= KINDS) ? PORT_AREA : MEM_AREA) + idx;
  endfunction

  function automatic logic [7:0] name_char(int idx, int k);
    int plen, slen, j;
    plen = pfx_len(idx);
    if (k < plen) return lit_byte((idx >= KINDS) ? PFX_PORT : PFX_MEM, plen, k);
    j    = k - plen;
    slen = sfx_len(idx % KINDS);
    if (j >= slen) return 8'h00;
    case (idx % KINDS)
      0:       return lit_byte(SFX_K0, slen, j);
      1:       return lit_byte(SFX_K1, slen, j);
      default: return lit_byte(SFX_K2, slen, j);
    endcase
  endfunction
endpackage

// File: rtl/wdet_hdr_view.sv
module wdet_hdr_view
  import wdet_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANES  = 4
) (
  input  logic              on,
  input  logic [IDX_W-1:0]  idx,
  input  logic [31:0]       count,
  input  logic [ADDR_W-1:0] base,
  input  logic [2:0]        size,
  output logic [8*LANES-1:0] bytes
);
  function automatic logic [7:0] hdr_byte(logic act, int i, logic [31:0] cnt, int a);
    logic [31:0] off;
    if (!act || (a + 1 >= hdr_len(i))) return 8'h00;
    off = 32'(test_offset(i));
    if (a == 0) return 8'(i);
    if (a == 1) return 8'h01;
    if (a >= 4 && a <= 7) return off[8*(a-4) +: 8];
    if (a == 8) return ((i % KINDS) == WILD_KIND) ? DATA_ANY : DATA_MATCH;
    if (a >= 12 && a <= 15) return cnt[8*(a-12) +: 8];
    if (a >= HDR_BYTES) return name_char(i, a - HDR_BYTES);
    return 8'h00;
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      if (k < int'(size))
        bytes[8*k +: 8] = hdr_byte(on, int'(idx), count, int'(base) + k);
      else
        bytes[8*k +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/wdet_ctrl.sv
module wdet_ctrl
  import wdet_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANES  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fire,
  input  logic               win,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [2:0]         size,
  input  logic [8*LANES-1:0] wdata,
  output logic               on,
  output logic [IDX_W-1:0]   idx,
  output logic [31:0]        count,
  output logic               sel
);
  logic       hit, qualify;
  logic [7:0] lane_byte;
  int         off, lane;

  assign sel = wr_fire && (addr == '0);

  always_comb begin
    off       = test_offset(int'(idx));
    lane      = off - int'(addr);
    hit       = on && (win == (int'(idx) >= KINDS)) && (lane >= 0) && (lane < int'(size));
    lane_byte = (lane >= 0 && lane < LANES) ? 8'(wdata >> (8 * lane)) : 8'h00;
    if ((int'(idx) % KINDS) == WILD_KIND)
      qualify = hit;
    else
      qualify = hit && (size == 3'd1) && (lane_byte == DATA_MATCH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on    <= 1'b0;
      idx   <= '0;
      count <= '0;
    end else if (sel) begin
      on    <= (wdata[7:0] < 8'(KINDS));
      idx   <= IDX_W'(int'(win) * KINDS + int'(wdata[1:0]));
      count <= '0;
    end else if (wr_fire && qualify) begin
      count <= count + 32'd1;
    end
  end
endmodule

// File: rtl/wdet_target.sv
module wdet_target
  import wdet_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int PORT_AW = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_win,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [2:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int LANES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] PORT_MASK = ADDR_W'((1 << PORT_AW) - 1);

  logic              fire, sel_fire, test_on;
  logic [ADDR_W-1:0] eff_addr;
  logic [IDX_W-1:0]  test_idx;
  logic [31:0]       wr_count;
  logic [DATA_W-1:0] rd_bytes;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign eff_addr  = req_win ? (req_addr & PORT_MASK) : req_addr;

  wdet_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_fire(fire && req_we), .win(req_win),
    .addr(eff_addr), .size(req_size), .wdata(req_wdata),
    .on(test_on), .idx(test_idx), .count(wr_count), .sel(sel_fire)
  );

  wdet_hdr_view #(.ADDR_W(ADDR_W), .LANES(LANES)) u_view (
    .on(test_on), .idx(test_idx), .count(wr_count),
    .base(eff_addr), .size(req_size), .bytes(rd_bytes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_we ? '0 : rd_bytes;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wdet_chk.sv
module wdet_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_we,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        test_on,
  input logic        sel_fire,
  input logic [31:0] wr_count
);
  // R10
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  // R10
  ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fire |=> wr_count == 32'd0);
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_fire |=> (wr_count == $past(wr_count)) || (wr_count == $past(wr_count) + 32'd1));
  // R1
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_we && !test_on |=> rsp_rdata == 32'd0);
endmodule

bind wdet_target wdet_chk u_chk (.*);

// File: tb/sim_wdet_target.sv
`timescale 1ns/1ps
module sim_wdet_target;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_win = 0, req_we = 0, rsp_ready = 1;
  logic [11:0] req_addr = 0;
  logic [2:0]  req_size = 1;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdet_target u0 (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic xfer(bit w, int a, bit we, int sz, logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_win = w; req_addr = 12'(a); req_we = we;
    req_size = 3'(sz); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    rd = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic wr(bit w, int a, int sz, logic [31:0] wd);
    logic [31:0] d;
    xfer(w, a, 1, sz, wd, d);
  endtask

  function automatic logic [31:0] rd_now_dummy();
    return 0;
  endfunction

  task automatic rd(bit w, int a, int sz, output logic [31:0] d);
    xfer(w, a, 0, sz, 0, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    rd(0, 0, 4, d); chk("R1 read hdr0", d, 0);
    rd(1, 12, 4, d); chk("R1 read count", d, 0);
  endtask

  task automatic t_select();
    logic [31:0] d;
    wr(0, 0, 1, 2);
    rd(0, 0, 4, d); chk("R2 R9 mem sel2 bytes0-3", d, 32'h0000_0102);
    rd(0, 4, 4, d); chk("R4 offset idx2", d, 32'h0000_0802);
    rd(0, 8, 4, d); chk("R4 data idx2", d, 32'h0000_00FA);
    wr(1, 0, 1, 1);
    rd(0, 0, 1, d); chk("R2 port sel1 idx", d, 32'h04);
    rd(1, 4, 2, d); chk("R4 R9 offset idx4", d, 32'h0084);
    rd(1, 8, 4, d); chk("R4 data idx4", d, 32'h0000_00CE);
    wr(0, 0, 1, 3);
    rd(0, 0, 4, d); chk("R2 sel3 none", d, 0);
  endtask

  task automatic t_name();
    logic [31:0] d;
    wr(0, 0, 1, 1);
    rd(0, 16, 4, d); chk("R5 name head", d, 32'h6f69_6d6d);
    rd(0, 36, 4, d); chk("R5 name tail", d, 32'h0000_0064);
    rd(0, 40, 4, d); chk("R5 past end", d, 0);
    wr(1, 0, 1, 2);
    rd(1, 20, 4, d); chk("R5 portio name", d, 32'h642d_6f69);
  endtask

  task automatic t_wild();
    logic [31:0] d;
    wr(0, 0, 1, 1);
    wr(0, 2049, 1, 32'h12);
    rd(0, 12, 4, d); chk("R6 size1 count", d, 1);
    wr(0, 2048, 4, 32'h0);
    wr(0, 2049, 2, 32'h55);
    rd(0, 12, 4, d); chk("R6 wide writes", d, 3);
    wr(0, 0, 1, 1);
    rd(0, 12, 4, d); chk("R3 restart clears", d, 0);
  endtask

  task automatic t_match();
    logic [31:0] d;
    wr(0, 0, 1, 2);
    wr(0, 2050, 1, 32'hFA);
    rd(0, 12, 4, d); chk("R7 match counted", d, 1);
    wr(0, 2050, 1, 32'h11);
    wr(0, 2048, 4, 32'h00FA_0000);
    wr(0, 2050, 2, 32'h00FA);
    rd(0, 12, 4, d); chk("R7 wrong data/size ignored", d, 1);
    wr(1, 0, 1, 0);
    wr(1, 131, 1, 32'hFA); wr(1, 131, 1, 32'hFA);
    rd(1, 12, 4, d); chk("R7 port match", d, 2);
    wr(1, 0, 1, 0);
    rd(1, 12, 4, d); chk("R3 port restart", d, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    wr(1, 0, 1, 1);
    wr(1, 131, 1, 32'hCE);
    wr(0, 132, 1, 32'hCE);
    wr(1, 134, 2, 32'h0);
    rd(1, 12, 4, d); chk("R8 misses ignored", d, 0);
    wr(1, 132 + 256, 1, 32'h0);
    rd(1, 12, 4, d); chk("R8 port addr aliasing counts", d, 1);
    wr(0, 0, 1, 9);
    wr(0, 2048, 4, 32'hFAFA_FAFA);
    wr(0, 0, 1, 0);
    rd(0, 12, 4, d); chk("R8 idle then fresh", d, 0);
  endtask

  task automatic t_backpressure();
    logic [31:0] first;
    wr(0, 0, 1, 0);
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_win = 0; req_addr = 0; req_we = 0; req_size = 4;
    @(negedge clk);
    req_valid = 0;
    chk("R10 rsp valid", {31'd0, rsp_valid}, 1);
    chk("R10 ready low", {31'd0, req_ready}, 0);
    first = rsp_rdata;
    chk("R10 data", first, 32'h0000_0100);
    @(negedge clk); @(negedge clk);
    chk("R10 still valid", {31'd0, rsp_valid}, 1);
    chk("R10 stable", rsp_rdata, first);
    rsp_ready = 1;
    @(negedge clk);
    chk("R10 drained", {31'd0, rsp_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_select();
    t_name();
    t_wild();
    t_match();
    t_ignore();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule